// File: doc/BRIEF.md
# Eight-Bit ALU With Condition Flags

This block is the arithmetic core of a small 8-bit processor datapath. Each cycle it takes an operation code, two byte operands, a 16-bit operand for wide moves and the current condition byte. One clock later it presents the byte result and the updated condition byte. Instruction decode, memory access and the interrupt-mask logic sit outside the block.

The condition byte has fixed bit positions because the branch and decimal logic around the block reads them directly: overflow at bit 7, half-carry at bit 4, interrupt mask at bit 3, negative at bit 2, zero at bit 1 and carry/borrow at bit 0. Bits 6, 5 and 3 are not owned by the block and are copied through unchanged. A decimal-adjust operation follows a binary add of two packed-BCD bytes. It uses the half-carry and carry that the add left behind to correct the sum back to valid BCD.

Top module: `alu8_flags`

## Requirements
- R1: Outputs are registered with one cycle of latency. A synchronous active-high reset drives `res_o` and `flags_o` to 0x00.
- R2: `flags_o` bits 6, 5 and 3 always equal the `flags_i` bits of the previous cycle.
- R3: Codes 0 (add) and 1 (add with carry-in from `flags_i` bit 0) give the byte sum. Carry bit 0 is the carry out of bit 7. Overflow bit 7 marks signed overflow. Half-carry bit 4 is the carry from bit 3 into bit 4.
- R4: Codes 2 (subtract) and 3 (subtract with borrow-in from `flags_i` bit 0) give A minus B. Bit 0 marks a borrow and bit 7 marks signed overflow. Half-carry is left unchanged.
- R5: For every code except 14 and 15, negative bit 2 equals result bit 7 and zero bit 1 is set exactly when the result is 0x00.
- R6: Codes 4 (AND), 5 (OR) and 6 (XOR) clear overflow and leave carry and half-carry unchanged.
- R7: Code 7 shifts left and code 8 shifts right with a zero fill. Code 9 shifts right and keeps bit 7. Code 10 rotates left through carry and code 11 rotates right through carry. In each case carry receives the bit shifted out, overflow becomes negative XOR carry, and half-carry is unchanged.
- R8: Code 12 (decimal adjust) adds 0x06 when the low nibble exceeds 9 or half-carry is set. It adds 0x60 when A exceeds 0x99 or carry is set, and carry then becomes 1; otherwise carry becomes 0. Overflow and half-carry are unchanged.
- R9: Code 13 (byte load) returns A and clears overflow. Code 14 (wide load) returns the low byte of W, sets negative from W bit 15 and zero when all 16 bits are zero, and clears overflow. Carry and half-carry are unchanged for both codes.
- R10: Code 15 returns A and leaves all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| w_i | input | 16 | Wide operand for 16-bit loads |
| flags_i | input | 8 | Current condition byte |
| res_o | output | 8 | Registered result |
| flags_o | output | 8 | Registered next condition byte |

## Verification
The sweeps target the carry-in paths: every add and subtract runs with both values of the incoming carry. A design that ignored carry-in for the chained forms, or inverted the borrow sense, would be wrong on half of those vectors. Signed overflow is checked across the 0x7F/0x80 boundary, where a design that compares the wrong sign bits reports overflow on ordinary sums. Decimal adjust is run over all 256 bytes with all four half-carry/carry combinations, which catches a wrong limit of 9 or 0x99 or a carry that is not forced. Wide loads with a zero low byte but a nonzero high byte catch a zero flag taken from only eight bits.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DATA_W = 8;
  localparam int WIDE_W = 16;
  localparam int FLG_W  = 8;
  localparam int FB_V = 7;
  localparam int FB_H = 4;
  localparam int FB_N = 2;
  localparam int FB_Z = 1;
  localparam int FB_C = 0;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
    OP_AND = 4'd4,  OP_OR  = 4'd5,  OP_XOR = 4'd6,  OP_LSL = 4'd7,
    OP_LSR = 4'd8,  OP_ASR = 4'd9,  OP_ROL = 4'd10, OP_ROR = 4'd11,
    OP_DAA = 4'd12, OP_LD8 = 4'd13, OP_LDW = 4'd14, OP_NOP = 4'd15
  } op_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         ovf,
  output logic         half
);
  localparam int NIB = W / 2;

  logic [W-1:0] b_eff;
  logic         c0;
  logic [W:0]   sum;
  logic [NIB:0] lo_sum;

  always_comb begin
    b_eff  = sub ? ~b : b;
    c0     = sub ? ~cin : cin;
    sum    = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c0};
    lo_sum = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c0};
    res    = sum[W-1:0];
    cout   = sub ? ~sum[W] : sum[W];
    ovf    = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    half   = lo_sum[NIB];
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);
  always_comb begin
    res  = a;
    cout = cin;
    case (op)
      OP_LSL: begin res = {a[W-2:0], 1'b0};    cout = a[W-1]; end
      OP_LSR: begin res = {1'b0, a[W-1:1]};    cout = a[0];   end
      OP_ASR: begin res = {a[W-1], a[W-1:1]};  cout = a[0];   end
      OP_ROL: begin res = {a[W-2:0], cin};     cout = a[W-1]; end
      OP_ROR: begin res = {cin, a[W-1:1]};     cout = a[0];   end
      default: begin res = a; cout = cin; end
    endcase
  end
endmodule

// File: rtl/alu8_bcd.sv
module alu8_bcd #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         h,
  input  logic         c,
  output logic [W-1:0] res,
  output logic         cout
);
  localparam int NIB = W / 2;
  localparam logic [NIB-1:0] DIGIT_MAX = NIB'(9);
  localparam logic [NIB-1:0] FIX       = NIB'(6);
  localparam logic [W-1:0]   BYTE_MAX  = {DIGIT_MAX, DIGIT_MAX};

  logic lo_fix, hi_fix;
  logic [W-1:0] corr;

  always_comb begin
    lo_fix = (a[NIB-1:0] > DIGIT_MAX) || h;
    hi_fix = (a > BYTE_MAX) || c;
    corr   = {hi_fix ? FIX : '0, lo_fix ? FIX : '0};
    res    = a + corr;
    cout   = hi_fix;
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [WIDE_W-1:0] w_i,
  input  logic [FLG_W-1:0]  flags_i,
  output logic [DATA_W-1:0] res_o,
  output logic [FLG_W-1:0]  flags_o
);
  op_e op;
  assign op = op_e'(op_i);

  logic              is_sub, use_cin;
  logic [DATA_W-1:0] as_res, sh_res, bcd_res;
  logic              as_c, as_v, as_h, sh_c, bcd_c;

  assign is_sub  = (op == OP_SUB) || (op == OP_SBC);
  assign use_cin = (op == OP_ADC) || (op == OP_SBC);

  alu8_addsub #(.W(DATA_W)) u_addsub (
    .a(a_i), .b(b_i), .cin(use_cin & flags_i[FB_C]), .sub(is_sub),
    .res(as_res), .cout(as_c), .ovf(as_v), .half(as_h)
  );

  alu8_shift #(.W(DATA_W)) u_shift (
    .op(op), .a(a_i), .cin(flags_i[FB_C]), .res(sh_res), .cout(sh_c)
  );

  alu8_bcd #(.W(DATA_W)) u_bcd (
    .a(a_i), .h(flags_i[FB_H]), .c(flags_i[FB_C]), .res(bcd_res), .cout(bcd_c)
  );

  logic [DATA_W-1:0] nxt_res;
  logic [FLG_W-1:0]  nxt_flg;
  logic              upd_nz;

  always_comb begin
    nxt_res = a_i;
    nxt_flg = flags_i;
    upd_nz  = 1'b1;
    case (op)
      OP_ADD, OP_ADC: begin
        nxt_res       = as_res;
        nxt_flg[FB_C] = as_c;
        nxt_flg[FB_V] = as_v;
        nxt_flg[FB_H] = as_h;
      end
      OP_SUB, OP_SBC: begin
        nxt_res       = as_res;
        nxt_flg[FB_C] = as_c;
        nxt_flg[FB_V] = as_v;
      end
      OP_AND: begin nxt_res = a_i & b_i; nxt_flg[FB_V] = 1'b0; end
      OP_OR:  begin nxt_res = a_i | b_i; nxt_flg[FB_V] = 1'b0; end
      OP_XOR: begin nxt_res = a_i ^ b_i; nxt_flg[FB_V] = 1'b0; end
      OP_LSL, OP_LSR, OP_ASR, OP_ROL, OP_ROR: begin
        nxt_res       = sh_res;
        nxt_flg[FB_C] = sh_c;
        nxt_flg[FB_V] = sh_res[DATA_W-1] ^ sh_c;
      end
      OP_DAA: begin
        nxt_res       = bcd_res;
        nxt_flg[FB_C] = bcd_c;
      end
      OP_LD8: begin
        nxt_res       = a_i;
        nxt_flg[FB_V] = 1'b0;
      end
      OP_LDW: begin
        nxt_res       = w_i[DATA_W-1:0];
        nxt_flg[FB_V] = 1'b0;
        nxt_flg[FB_N] = w_i[WIDE_W-1];
        nxt_flg[FB_Z] = (w_i == '0);
        upd_nz        = 1'b0;
      end
      default: upd_nz = 1'b0;
    endcase
    if (upd_nz) begin
      nxt_flg[FB_N] = nxt_res[DATA_W-1];
      nxt_flg[FB_Z] = (nxt_res == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      flags_o <= '0;
    end else begin
      res_o   <= nxt_res;
      flags_o <= nxt_flg;
    end
  end
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
  import alu8_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [3:0]        op_i,
  input logic [FLG_W-1:0]  flags_i,
  input logic [DATA_W-1:0] res_o,
  input logic [FLG_W-1:0]  flags_o
);
  logic is_logic, is_shift, is_add, is_8bit;
  assign is_logic = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR);
  assign is_shift = (op_i >= OP_LSL) && (op_i <= OP_ROR);
  assign is_add   = (op_i == OP_ADD) || (op_i == OP_ADC);
  assign is_8bit  = (op_i != OP_LDW) && (op_i != OP_NOP);

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (res_o == '0) && (flags_o == '0)); // R1

  AST_SPARE_BITS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (flags_o[6:5] == $past(flags_i[6:5])) && (flags_o[3] == $past(flags_i[3]))); // R2

  AST_NZ_TRACK: assert property (@(posedge clk) disable iff (rst)
    is_8bit |=> (flags_o[FB_N] == res_o[DATA_W-1]) && (flags_o[FB_Z] == (res_o == '0))); // R5

  AST_HALF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!is_add && op_i != OP_NOP) |=> flags_o[FB_H] == $past(flags_i[FB_H])); // R4

  AST_LOGIC_FLAGS: assert property (@(posedge clk) disable iff (rst)
    is_logic |=> !flags_o[FB_V] && (flags_o[FB_C] == $past(flags_i[FB_C]))); // R6

  AST_SHIFT_OVF: assert property (@(posedge clk) disable iff (rst)
    is_shift |=> flags_o[FB_V] == (flags_o[FB_N] ^ flags_o[FB_C])); // R7

  AST_BCD_CARRY: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_DAA && flags_i[FB_C]) |=> flags_o[FB_C]); // R8

  AST_NOP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_NOP) |=> flags_o == $past(flags_i)); // R10
endmodule

bind alu8_flags alu8_flags_chk u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .flags_i(flags_i),
  .res_o(res_o), .flags_o(flags_o)
);

// File: tb/alu8_flags_bench.sv
module alu8_flags_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_i = '0;
  logic [7:0]  a_i = '0, b_i = '0;
  logic [15:0] w_i = '0;
  logic [7:0]  flags_i = '0;
  logic [7:0]  res_o, flags_o;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  alu8_flags u_alu8_flags (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .w_i(w_i), .flags_i(flags_i), .res_o(res_o), .flags_o(flags_o)
  );

  function automatic string req_of(int op);
    if (op <= 1)  return "R3";
    if (op <= 3)  return "R4";
    if (op <= 6)  return "R6";
    if (op <= 11) return "R7";
    if (op == 12) return "R8";
    if (op <= 14) return "R9";
    return "R10";
  endfunction

  // Reference: returns {result, flags}
  function automatic logic [15:0] model(int op, int a, int b, int w, logic [7:0] f);
    int r, sa, sb, s, ci, corr;
    logic [7:0] o;
    logic nz;
    o = f; r = a; nz = 1'b1;
    ci = f[0];
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    case (op)
      0, 1: begin
        if (op == 0) ci = 0;
        r = a + b + ci; o[0] = (r > 255);
        s = sa + sb + ci; o[7] = (s > 127) || (s < -128);
        o[4] = ((a % 16) + (b % 16) + ci) > 15;
        r = r % 256;
      end
      2, 3: begin
        if (op == 2) ci = 0;
        r = a - b - ci; o[0] = (r < 0);
        s = sa - sb - ci; o[7] = (s > 127) || (s < -128);
        r = (r + 512) % 256;
      end
      4: begin r = a & b; o[7] = 0; end
      5: begin r = a | b; o[7] = 0; end
      6: begin r = a ^ b; o[7] = 0; end
      7, 8, 9, 10, 11: begin
        case (op)
          7:  begin r = (a * 2) % 256;            o[0] = a >= 128; end
          8:  begin r = a / 2;                    o[0] = a % 2;    end
          9:  begin r = a / 2 + (a & 128);        o[0] = a % 2;    end
          10: begin r = (a * 2) % 256 + ci;       o[0] = a >= 128; end
          default: begin r = a / 2 + 128 * ci;    o[0] = a % 2;    end
        endcase
        o[7] = (r >= 128) ^ o[0];
      end
      12: begin
        corr = 0;
        if ((a % 16) > 9 || f[4]) corr += 6;
        if (a > 153 || f[0]) begin corr += 96; o[0] = 1; end
        else o[0] = 0;
        r = (a + corr) % 256;
      end
      13: begin r = a; o[7] = 0; end
      14: begin
        r = w % 256; o[7] = 0; o[2] = (w >= 32768); o[1] = (w == 0); nz = 0;
      end
      default: begin r = a; nz = 0; end
    endcase
    if (nz) begin o[2] = (r >= 128); o[1] = (r == 0); end
    return {8'(r), o};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: res/flags actual %h/%b expected %h/%b",
               req, act[15:8], act[7:0], exp[15:8], exp[7:0]);
    end
  endtask

  // Drive at a negedge, sample at the next negedge (one register)
  task automatic run(int op, int a, int b, int w, logic [7:0] f);
    op_i = 4'(op); a_i = 8'(a); b_i = 8'(b); w_i = 16'(w); flags_i = f;
    @(posedge clk); @(negedge clk);
    check(req_of(op), {res_o, flags_o}, model(op, a, b, w, f));
    if (op != 14 && op != 15)
      check("R5", {7'b0, flags_o[2], 7'b0, flags_o[1]}, {7'b0, res_o[7], 7'b0, res_o == 0});
    check("R2", {13'b0, flags_o[6:5], flags_o[3]}, {13'b0, f[6:5], f[3]});
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", {res_o, flags_o}, 16'h0000);
    rst = 1'b0;
    // R3 / R5 directed corners
    run(0, 8'h80, 8'h80, 0, 8'h00);  // zero with carry and overflow
    run(0, 8'h7F, 8'h01, 0, 8'h00);  // signed overflow, half carry
    run(1, 8'hFF, 8'h00, 0, 8'h01);  // carry-in ripples to zero
    run(3, 8'h00, 8'h00, 0, 8'h01);  // R4 borrow-in gives 0xFF
    run(12, 8'h9A, 0, 0, 8'h00);     // R8 both fixes
    run(14, 0, 0, 16'h0100, 8'h00);  // R9 low byte zero, Z clear
    run(14, 0, 0, 16'h0000, 8'h00);
    run(14, 0, 0, 16'h8000, 8'h00);
    run(15, 8'h00, 0, 0, 8'hFF);     // R10
    // sweeps over every code, both carry and half-carry values
    for (int op = 0; op < 16; op++)
      for (int k = 0; k < 4; k++)
        for (int a = 0; a < 256; a++) begin
          int nb;
          logic [7:0] f;
          f  = {k[1], k[0], ~k[0], k[1], ~k[1], k[0] ^ k[1], k[1], k[0]};
          nb = (op <= 3) ? 16 : 2;
          for (int j = 0; j < nb; j++) begin
            int b;
            b = (op <= 3) ? j * 17 : (a * 7 + 13 + j * 91) % 256;
            run(op, a, b, (b * 256 + (a ^ 8'h3C)) % 65536, f);
          end
        end
    // R1 reset mid-run
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1", {res_o, flags_o}, 16'h0000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule